// File: doc/BRIEF.md
# Signature-Verify Mailbox Command Sequencer

This block is a hardware master that hands a 384-bit elliptic-curve signature check to a mailbox-based security engine. It takes a public key (x, y) and a signature (r, s), each 48 bytes wide, on parallel inputs. A one-cycle `start` sets it running. The block claims the mailbox by polling its lock word and confirms that the mailbox is in the ready-for-command phase. It then writes the verify command, the payload length, a checksum word and the four operands, and launches execution. It polls the result code until the engine leaves the busy state, releases execution, and ends with a single `done` pulse and one result flag.

The checksum is computed while the lock is being acquired. It is a running 32-bit value that starts at zero and has every payload byte subtracted from it. The first write to the data port waits until the checksum is ready, so a slow lock grant hides the checksum time completely. The operand inputs must stay stable from `start` until `done`.

All mailbox traffic goes over a single-outstanding register-bus master port. The master holds a request until the slave acknowledges it, and read data is taken in the acknowledge cycle.

Top module: `sigver_mbox_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done`, all four result flags and `bus_req` are 0 after that edge.
- R2: `start` is accepted only while the sequencer is idle; a `start` during a run changes neither the bus transaction sequence nor the number of `done` pulses.
- R3: After an accepted start, the lock word at offset 0x00 is read until it returns 0. If `LOCK_POLL_MAX` consecutive reads return non-zero, the run ends with `err_lock_busy` and issues no write.
- R4: After the lock is gained, the status word at offset 0x1C is read once. If its bits [8:6] are not 1 (ready for command), the run ends with `err_bad_phase` and issues no write.
- R5: The writes are, in order: 0x53494756 to offset 0x08, the byte count 196 to offset 0x0C, then 49 words to offset 0x10. These are the checksum word followed by 12 words each of x, y, r and s. Word k of an operand is its bits [32k+31:32k].
- R6: The checksum word equals 0 minus the four bytes of 0x53494756, minus all 192 operand bytes, modulo 2^32. Operand byte i is bits [8i+7:8i].
- R7: After the last operand word, 1 is written to offset 0x18. Status at 0x1C is then read while its bits [3:0] are 0 (busy). After the first non-busy read, 0 is written to offset 0x18.
- R8: A final status code of 3 ends the run with `vfy_fail`; any other non-busy code ends it with `vfy_pass`.
- R9: `done` is high for exactly one cycle, two cycles after the acknowledge edge of the run's last transaction, and exactly one result flag is then set. The flags hold until the next accepted start, which clears them for the following cycle.
- R10: Once raised, `bus_req` stays high with `bus_we`, `bus_addr` and `bus_wdata` unchanged until a cycle in which `bus_ack` is high; the transfer completes at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a verify run (honoured only when idle) |
| key_x | input | 384 | Public key x, byte i at bits [8i+7:8i] |
| key_y | input | 384 | Public key y |
| sig_r | input | 384 | Signature r |
| sig_s | input | 384 | Signature s |
| done | output | 1 | One-cycle end-of-run pulse |
| vfy_pass | output | 1 | Engine reported a non-failure result |
| vfy_fail | output | 1 | Engine reported failure code 3 |
| err_lock_busy | output | 1 | Lock not gained within the poll limit |
| err_bad_phase | output | 1 | Mailbox not ready for a command after locking |
| bus_req | output | 1 | Transfer request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Mailbox byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Slave acknowledge; transfer completes at this edge |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
Two of the block's functions can land in the same cycle. One is the background checksum engine finishing its last subtraction. The other is the command sequencer reaching the checksum-write step after the lock grant and the command and length writes. The bench sweeps the number of busy lock reads over a range that slides the arrival across the checksum's completion cycle. Each run is judged by the exact write order, the checksum value carried by the first data-port write, and the cycle-exact position of `done`, all compared on every clock against a behavioural model.

// File: rtl/sigmb_pkg.sv
// Package: shared constants, state encoding and bus-operation type for the
// signature-verify mailbox sequencer.
// Assumes: the mailbox decodes byte offsets over an 8-bit address field.
package sigmb_pkg;

    localparam int MB_AW = 8;

    // Mailbox register offsets decoded by the slave
    localparam logic [MB_AW-1:0] OFS_LOCK = 8'h00;
    localparam logic [MB_AW-1:0] OFS_CMD  = 8'h08;
    localparam logic [MB_AW-1:0] OFS_DLEN = 8'h0C;
    localparam logic [MB_AW-1:0] OFS_DIN  = 8'h10;
    localparam logic [MB_AW-1:0] OFS_EXEC = 8'h18;
    localparam logic [MB_AW-1:0] OFS_STAT = 8'h1C;

    // Command code and status field encodings
    localparam logic [31:0] VERIFY_CMD      = 32'h5349_4756;
    localparam int          PHASE_LSB       = 6;
    localparam int          PHASE_MSB       = 8;
    localparam logic [2:0]  PHASE_READY_CMD = 3'd1;
    localparam logic [3:0]  ST_BUSY         = 4'd0;
    localparam logic [3:0]  ST_FAIL         = 4'd3;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_LOCK,
        SQ_PHASE,
        SQ_CMD,
        SQ_DLEN,
        SQ_CSUM,
        SQ_DATA,
        SQ_EXEC_SET,
        SQ_STAT,
        SQ_EXEC_CLR
    } seq_state_e;

    typedef struct packed {
        logic             we;
        logic [MB_AW-1:0] addr;
        logic [31:0]      data;
    } mb_op_t;

    // Sum of the four bytes of a word, zero-extended to 32 bits
    function automatic logic [31:0] byte_sum(input logic [31:0] w);
        return {24'd0, w[7:0]} + {24'd0, w[15:8]} + {24'd0, w[23:16]} + {24'd0, w[31:24]};
    endfunction

endpackage

// File: rtl/sigmb_wordsel.sv
// Module: picks one 32-bit word out of the concatenated operand vector.
// Assumes: sel < NWORDS; word k is bits [32k+31:32k] (little-endian packing).
module sigmb_wordsel #(
    parameter int NWORDS = 48,
    localparam int IDX_W = $clog2(NWORDS + 1)
) (
    input  logic [NWORDS*32-1:0] words,
    input  logic [IDX_W-1:0]     sel,
    output logic [31:0]          word
);

    // Word multiplexer
    always_comb begin
        word = words[sel*32 +: 32];
    end

endmodule

// File: rtl/sigmb_csum.sv
// Module: background checksum engine. On launch it seeds the sum with the
// command bytes subtracted from zero, then subtracts the four bytes of one
// operand word per cycle, raising ready after the last word.
// Assumes: words stay stable from launch until ready.
module sigmb_csum
    import sigmb_pkg::*;
#(
    parameter int NWORDS = 48,
    localparam int IDX_W = $clog2(NWORDS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic [NWORDS*32-1:0] words,
    output logic                 ready,
    output logic [31:0]          sum
);

    localparam logic [31:0]      SEED     = 32'd0 - byte_sum(VERIFY_CMD);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

    logic             active;
    logic [IDX_W-1:0] idx;
    logic [31:0]      cur_word;

    sigmb_wordsel #(.NWORDS(NWORDS)) u_sel (
        .words (words),
        .sel   (idx),
        .word  (cur_word)
    );

    // Walk the operand words, subtracting their bytes from the running sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            ready  <= 1'b0;
            sum    <= '0;
        end else if (launch) begin
            active <= 1'b1;
            idx    <= '0;
            ready  <= 1'b0;
            sum    <= SEED;
        end else if (active) begin
            sum <= sum - byte_sum(cur_word);
            if (idx == LAST_IDX) begin
                active <= 1'b0;
                ready  <= 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx <= LAST_IDX));

    // R6
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !launch) |=> (ready && $stable(sum)));

endmodule

// File: rtl/sigmb_busport.sv
// Module: single-outstanding register-bus master. Captures one operation
// when idle, holds the request until acknowledged, then pulses op_fin for
// one cycle with the captured read data.
// Assumes: the requester keeps op stable while op_valid is high and changes
// it only after op_fin.
module sigmb_busport
    import sigmb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  mb_op_t           op,
    output logic             op_fin,
    output logic [31:0]      op_rdata,
    output logic             bus_req,
    output logic             bus_we,
    output logic [MB_AW-1:0] bus_addr,
    output logic [31:0]      bus_wdata,
    input  logic             bus_ack,
    input  logic [31:0]      bus_rdata
);

    // Launch, hold and retire one bus transfer at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            op_fin    <= 1'b0;
            op_rdata  <= '0;
        end else begin
            op_fin <= 1'b0;
            if (bus_req && bus_ack) begin
                bus_req  <= 1'b0;
                op_fin   <= 1'b1;
                op_rdata <= bus_rdata;
            end else if (!bus_req && !op_fin && op_valid) begin
                bus_req   <= 1'b1;
                bus_we    <= op.we;
                bus_addr  <= op.addr;
                bus_wdata <= op.data;
            end
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

    // R10
    req_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (!bus_req && op_fin));

endmodule

// File: rtl/sigver_mbox_seq.sv
// Module: signature-verify mailbox command sequencer (top). Acquires the
// mailbox lock, checks the phase, writes command, length, checksum and
// operands, executes, polls the result and releases execution.
// Assumes: PARAM_BYTES is a multiple of 4; operand inputs are stable from
// start until done; the slave serves one transfer at a time.
module sigver_mbox_seq
    import sigmb_pkg::*;
#(
    parameter int PARAM_BYTES   = 48,
    parameter int LOCK_POLL_MAX = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [PARAM_BYTES*8-1:0] key_x,
    input  logic [PARAM_BYTES*8-1:0] key_y,
    input  logic [PARAM_BYTES*8-1:0] sig_r,
    input  logic [PARAM_BYTES*8-1:0] sig_s,
    output logic                     done,
    output logic                     vfy_pass,
    output logic                     vfy_fail,
    output logic                     err_lock_busy,
    output logic                     err_bad_phase,
    output logic                     bus_req,
    output logic                     bus_we,
    output logic [MB_AW-1:0]         bus_addr,
    output logic [31:0]              bus_wdata,
    input  logic                     bus_ack,
    input  logic [31:0]              bus_rdata
);

    localparam int WPP    = PARAM_BYTES / 4;
    localparam int NWORDS = 4 * WPP;
    localparam int IDX_W  = $clog2(NWORDS + 1);
    localparam int CNT_W  = $clog2(LOCK_POLL_MAX + 1);
    localparam logic [31:0]      DLEN_BYTES = 32'(4 + 4 * PARAM_BYTES);
    localparam logic [IDX_W-1:0] LAST_WORD  = IDX_W'(NWORDS - 1);
    localparam logic [CNT_W-1:0] LAST_POLL  = CNT_W'(LOCK_POLL_MAX - 1);

    seq_state_e        state;
    logic [CNT_W-1:0]  poll_cnt;
    logic [IDX_W-1:0]  widx;
    logic [3:0]        stat_code;
    logic [NWORDS*32-1:0] words;
    logic [31:0]       param_word;
    logic              csum_launch;
    logic              csum_ready;
    logic [31:0]       csum_val;
    logic              op_valid;
    mb_op_t            op;
    logic              op_fin;
    logic [31:0]       op_rdata;
    logic [3:0]        flags;

    assign words       = {sig_s, sig_r, key_y, key_x};
    assign csum_launch = (state == SQ_IDLE) && start;
    assign flags       = {vfy_pass, vfy_fail, err_lock_busy, err_bad_phase};

    sigmb_csum #(.NWORDS(NWORDS)) u_csum (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (csum_launch),
        .words  (words),
        .ready  (csum_ready),
        .sum    (csum_val)
    );

    sigmb_wordsel #(.NWORDS(NWORDS)) u_psel (
        .words (words),
        .sel   (widx),
        .word  (param_word)
    );

    sigmb_busport u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op        (op),
        .op_fin    (op_fin),
        .op_rdata  (op_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata)
    );

    // Decode the bus operation the current step needs
    always_comb begin
        op_valid = 1'b1;
        op       = '{we: 1'b0, addr: OFS_LOCK, data: 32'd0};
        unique case (state)
            SQ_IDLE:     op_valid = 1'b0;
            SQ_LOCK:     op = '{we: 1'b0, addr: OFS_LOCK, data: 32'd0};
            SQ_PHASE:    op = '{we: 1'b0, addr: OFS_STAT, data: 32'd0};
            SQ_CMD:      op = '{we: 1'b1, addr: OFS_CMD,  data: VERIFY_CMD};
            SQ_DLEN:     op = '{we: 1'b1, addr: OFS_DLEN, data: DLEN_BYTES};
            SQ_CSUM: begin
                op_valid = csum_ready;
                op       = '{we: 1'b1, addr: OFS_DIN, data: csum_val};
            end
            SQ_DATA:     op = '{we: 1'b1, addr: OFS_DIN,  data: param_word};
            SQ_EXEC_SET: op = '{we: 1'b1, addr: OFS_EXEC, data: 32'd1};
            SQ_STAT:     op = '{we: 1'b0, addr: OFS_STAT, data: 32'd0};
            SQ_EXEC_CLR: op = '{we: 1'b1, addr: OFS_EXEC, data: 32'd0};
            default:     op_valid = 1'b0;
        endcase
    end

    // Step the command sequence on each retired transfer and post the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= SQ_IDLE;
            poll_cnt      <= '0;
            widx          <= '0;
            stat_code     <= '0;
            done          <= 1'b0;
            vfy_pass      <= 1'b0;
            vfy_fail      <= 1'b0;
            err_lock_busy <= 1'b0;
            err_bad_phase <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (start) begin
                        vfy_pass      <= 1'b0;
                        vfy_fail      <= 1'b0;
                        err_lock_busy <= 1'b0;
                        err_bad_phase <= 1'b0;
                        poll_cnt      <= '0;
                        widx          <= '0;
                        state         <= SQ_LOCK;
                    end
                end
                SQ_LOCK: begin
                    if (op_fin) begin
                        if (op_rdata == 32'd0) begin
                            state <= SQ_PHASE;
                        end else if (poll_cnt == LAST_POLL) begin
                            err_lock_busy <= 1'b1;
                            done          <= 1'b1;
                            state         <= SQ_IDLE;
                        end else begin
                            poll_cnt <= poll_cnt + 1'b1;
                        end
                    end
                end
                SQ_PHASE: begin
                    if (op_fin) begin
                        if (op_rdata[PHASE_MSB:PHASE_LSB] == PHASE_READY_CMD) begin
                            state <= SQ_CMD;
                        end else begin
                            err_bad_phase <= 1'b1;
                            done          <= 1'b1;
                            state         <= SQ_IDLE;
                        end
                    end
                end
                SQ_CMD:  if (op_fin) state <= SQ_DLEN;
                SQ_DLEN: if (op_fin) state <= SQ_CSUM;
                SQ_CSUM: if (op_fin) state <= SQ_DATA;
                SQ_DATA: begin
                    if (op_fin) begin
                        if (widx == LAST_WORD) begin
                            state <= SQ_EXEC_SET;
                        end else begin
                            widx <= widx + 1'b1;
                        end
                    end
                end
                SQ_EXEC_SET: if (op_fin) state <= SQ_STAT;
                SQ_STAT: begin
                    if (op_fin && (op_rdata[3:0] != ST_BUSY)) begin
                        stat_code <= op_rdata[3:0];
                        state     <= SQ_EXEC_CLR;
                    end
                end
                SQ_EXEC_CLR: begin
                    if (op_fin) begin
                        done <= 1'b1;
                        if (stat_code == ST_FAIL) vfy_fail <= 1'b1;
                        else                      vfy_pass <= 1'b1;
                        state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(flags) == 1));

    // R9
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags));

    // R9
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csum_launch |=> (done || $stable(flags)));

    // R9
    flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csum_launch |=> (flags == 4'd0));

    // R6
    csum_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && (bus_addr == OFS_DIN)) |-> csum_ready);

endmodule

// File: tb/test_sigver_mbox_seq.sv
module test_sigver_mbox_seq;

    localparam int PB  = 48;
    localparam int LIM = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [PB*8-1:0] kx = '0, ky = '0, sr = '0, ss = '0;
    logic          done, vfy_pass, vfy_fail, err_lock_busy, err_bad_phase;
    logic          bus_req, bus_we;
    logic [7:0]    bus_addr;
    logic [31:0]   bus_wdata;
    logic          bus_ack = 1'b0;
    logic [31:0]   bus_rdata = '0;

    always #10 clk = ~clk;

    sigver_mbox_seq #(.PARAM_BYTES(PB), .LOCK_POLL_MAX(LIM)) i_sigver_mbox_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .key_x(kx), .key_y(ky), .sig_r(sr), .sig_s(ss),
        .done(done), .vfy_pass(vfy_pass), .vfy_fail(vfy_fail),
        .err_lock_busy(err_lock_busy), .err_bad_phase(err_bad_phase),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [40:0] exp_q[$];
    string       tag_q[$];
    int cfg_lock_busy = 0, cfg_stat_busy = 0, cfg_lat = 0;
    logic [2:0] cfg_phase = 3'd1;
    logic [3:0] cfg_code  = 4'd2;
    int lock_rds = 0, stat_rds = 0, wait_cnt = 0, since = 0, dones = 0;
    bit phase_read = 0, emptied = 0;
    logic [3:0] exp_flags = 4'd0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] model_csum();
        logic [31:0] c = 32'd0;
        logic [31:0] cmd = 32'h5349_4756;
        for (int b = 0; b < 4; b++) c = c - ((cmd >> (8 * b)) & 32'hFF);
        for (int i = 0; i < PB; i++) begin
            c = c - {24'd0, kx[8*i +: 8]};
            c = c - {24'd0, ky[8*i +: 8]};
            c = c - {24'd0, sr[8*i +: 8]};
            c = c - {24'd0, ss[8*i +: 8]};
        end
        return c;
    endfunction

    task automatic push(input bit we, input logic [7:0] a, input logic [31:0] d, input string t);
        exp_q.push_back({we, a, d});
        tag_q.push_back(t);
    endtask

    // Behavioural model of the expected transaction list and result
    task automatic build_model();
        int nl;
        exp_q.delete();
        tag_q.delete();
        nl = (cfg_lock_busy >= LIM) ? LIM : cfg_lock_busy + 1;
        for (int i = 0; i < nl; i++) push(1'b0, 8'h00, 32'd0, "R3 lock read");
        if (cfg_lock_busy >= LIM) begin exp_flags = 4'b0010; return; end
        push(1'b0, 8'h1C, 32'd0, "R4 phase read");
        if (cfg_phase != 3'd1) begin exp_flags = 4'b0001; return; end
        push(1'b1, 8'h08, 32'h5349_4756, "R5 command write");
        push(1'b1, 8'h0C, 32'd196, "R5 length write");
        push(1'b1, 8'h10, model_csum(), "R6 checksum word");
        for (int k = 0; k < PB / 4; k++) push(1'b1, 8'h10, kx[32*k +: 32], "R5 x word");
        for (int k = 0; k < PB / 4; k++) push(1'b1, 8'h10, ky[32*k +: 32], "R5 y word");
        for (int k = 0; k < PB / 4; k++) push(1'b1, 8'h10, sr[32*k +: 32], "R5 r word");
        for (int k = 0; k < PB / 4; k++) push(1'b1, 8'h10, ss[32*k +: 32], "R5 s word");
        push(1'b1, 8'h18, 32'd1, "R7 execute set");
        for (int i = 0; i <= cfg_stat_busy; i++) push(1'b0, 8'h1C, 32'd0, "R7 status poll");
        push(1'b1, 8'h18, 32'd0, "R7 execute clear");
        exp_flags = (cfg_code == 4'd3) ? 4'b0100 : 4'b1000;
    endtask

    // Per-clock comparison and mailbox slave model
    always @(negedge clk) begin
        logic [40:0] e;
        string t;
        logic [3:0] code;
        if (rst_n) begin
            if (emptied) since++;
            chk(done == (emptied && since == 2), "R9 done timing", done, emptied && since == 2);
            if (done) begin
                dones++;
                emptied = 0;
            end
        end
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (wait_cnt < cfg_lat) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                bus_ack  = 1'b1;
                bus_rdata = 32'd0;
                if (!bus_we && bus_addr == 8'h00) begin
                    bus_rdata = (lock_rds < cfg_lock_busy) ? 32'd1 : 32'd0;
                    lock_rds++;
                end else if (!bus_we && bus_addr == 8'h1C) begin
                    if (!phase_read) begin
                        bus_rdata  = {23'd0, cfg_phase, 2'b00, 4'd0};
                        phase_read = 1;
                    end else begin
                        code = (stat_rds < cfg_stat_busy) ? 4'd0 : cfg_code;
                        bus_rdata = {23'd0, 3'd4, 2'b00, code};
                        stat_rds++;
                    end
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected transfer", {bus_we, bus_addr, bus_wdata}, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({bus_we, bus_addr} == e[40:32], t, {bus_we, bus_addr}, e[40:32]);
                    if (e[40]) chk(bus_wdata == e[31:0], t, bus_wdata, e[31:0]);
                    if (exp_q.size() == 0) begin
                        emptied = 1;
                        since   = 0;
                    end
                end
            end
        end
    end

    task automatic set_params(input int mode);
        for (int i = 0; i < PB; i++) begin
            case (mode)
                0: begin kx[8*i +: 8] = 8'(i * 7 + 1); ky[8*i +: 8] = 8'(i * 13 + 5);
                         sr[8*i +: 8] = 8'(255 - i);   ss[8*i +: 8] = 8'(i) ^ 8'h5A; end
                1: begin kx[8*i +: 8] = 8'hFF; ky[8*i +: 8] = 8'hFF; sr[8*i +: 8] = 8'hFF; ss[8*i +: 8] = 8'hFF; end
                2: begin kx[8*i +: 8] = 8'h00; ky[8*i +: 8] = 8'h00; sr[8*i +: 8] = 8'h00; ss[8*i +: 8] = 8'h00; end
                default: begin kx[8*i +: 8] = 8'(i * 29); ky[8*i +: 8] = 8'(200 - i * 3);
                               sr[8*i +: 8] = 8'(i * i); ss[8*i +: 8] = 8'(i + 100); end
            endcase
        end
    endtask

    task automatic run(input int lb, input logic [2:0] ph, input int sb, input logic [3:0] code,
                       input int lat, input bit extra_start);
        int prev;
        int g;
        cfg_lock_busy = lb; cfg_phase = ph; cfg_stat_busy = sb; cfg_code = code; cfg_lat = lat;
        lock_rds = 0; stat_rds = 0; phase_read = 0; wait_cnt = 0;
        build_model();
        prev = dones;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({vfy_pass, vfy_fail, err_lock_busy, err_bad_phase} == 4'd0, "R9 flags cleared by start",
            {vfy_pass, vfy_fail, err_lock_busy, err_bad_phase}, 0);
        if (extra_start) begin
            repeat (25) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        g = 0;
        while (dones == prev && g < 20000) begin
            @(negedge clk);
            g++;
        end
        chk(g < 20000, "R9 run finished", g, 20000);
        chk({vfy_pass, vfy_fail, err_lock_busy, err_bad_phase} == exp_flags, "R8 result flags",
            {vfy_pass, vfy_fail, err_lock_busy, err_bad_phase}, exp_flags);
        chk(exp_q.size() == 0, "R5 all transfers seen", exp_q.size(), 0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0 && bus_req == 1'b0, "R1 reset outputs", {done, bus_req}, 0);
        chk({vfy_pass, vfy_fail, err_lock_busy, err_bad_phase} == 4'd0, "R1 reset flags",
            {vfy_pass, vfy_fail, err_lock_busy, err_bad_phase}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        set_params(0);
        run(0, 3'd1, 3, 4'd2, 0, 0);       // R5 R6 R7 R8 pass path
        run(4, 3'd1, 1, 4'd3, 2, 0);       // R8 failure code
        run(2, 3'd1, 0, 4'd1, 1, 0);       // R8 data-ready counts as pass
        run(1000, 3'd1, 0, 4'd2, 0, 0);    // R3 lock never free
        run(LIM - 1, 3'd1, 0, 4'd2, 0, 0); // R3 granted on the last allowed read
        run(0, 3'd0, 0, 4'd2, 1, 0);       // R4 wrong phase
        run(0, 3'd5, 0, 4'd2, 0, 0);       // R4 another wrong phase
        run(1, 3'd1, 2, 4'd2, 0, 1);       // R2 start during run ignored

        // R9 flags held while idle
        repeat (10) @(negedge clk);
        chk({vfy_pass, vfy_fail, err_lock_busy, err_bad_phase} == 4'b1000, "R9 flags held",
            {vfy_pass, vfy_fail, err_lock_busy, err_bad_phase}, 4'b1000);
        chk(done == 1'b0, "R9 no stray done", done, 0);

        set_params(1);
        run(0, 3'd1, 0, 4'd3, 0, 0);       // R6 all-ones operands
        set_params(2);
        run(3, 3'd1, 5, 4'd2, 3, 0);       // R6 all-zero operands
        set_params(3);
        for (int lb = 6; lb <= 14; lb++) run(lb, 3'd1, 1, 4'd2, 0, 0); // R6 checksum ready vs arrival

        repeat (20) @(negedge clk);
        summary();
        $finish;
    end

endmodule